// File: doc/BRIEF.md
# Dual-Channel Successive-Approximation Scan Sequencer

This block is the digital control for two successive-approximation converter channels that run side by side. Each channel has its own 8-way analogue input selector and its own enable mask naming which selector inputs form its scan list. A scan starts on a software start strobe, or on a hardware trigger pulse when that source is enabled. The sequencer then steps through the lists one conversion at a time. In each step both channels sample together and then resolve their bits together. Each channel works on its next enabled input, taken in ascending input order. A channel whose list runs out sits idle while the other channel finishes its list.

Each conversion step has two phases. The sample phase lasts a base of two clocks plus an extension of 0 to 15 clocks, for sources of higher impedance. The bit-trial phase takes one clock per result bit, most significant bit first, at a resolution of 6, 8, 10 or 12 bits. During each trial the block drives a trial code to the external capacitor DAC and reads back the comparator. Every result is stored left-aligned in a 12-bit register belonging to its (channel, input) slot. The registers can be read through a combinational read port. A one-cycle interrupt pulse marks the end of the whole scan.

The controller has three states. IDLE is the rest state. SAMPLE is the acquisition phase, common to both channels. CONVERT is the bit-trial phase. The transitions are:
- IDLE to SAMPLE, on an accepted trigger.
- SAMPLE to CONVERT, when the sample count expires.
- CONVERT to SAMPLE, after the last bit when either list has inputs left.
- CONVERT to IDLE, after the last bit of the final step. This transition raises the interrupt.

Top module: `adc_scan_seq`

## Requirements
- R1: A scan starts when `sw_start` is high, or when `hw_trig` is high while `hw_trig_en` is high, at a clock edge in IDLE; `busy` is high in the following cycle. A `hw_trig` pulse with `hw_trig_en` low starts nothing.
- R2: A trigger while both enable masks are zero is ignored: `busy` stays low and no interrupt is raised.
- R3: In step k of a scan, channel c drives the index of the k-th lowest set bit of its mask on `mux_sel` (bits [3c+2:3c]). The two channels sample in the same cycles. `mux_sel` does not change during a bit-trial phase.
- R4: Each sample phase (`sample_hold` high) lasts 2 + `sample_ext` clocks, where `sample_ext` is the value captured at the trigger.
- R5: The trial phase lasts N clocks, with N = 6 + 2*`res_sel` (00 gives 6, 01 gives 8, 10 gives 10, 11 gives 12). The first trial code on `dac_code` is 12'h800, with only the MSB set.
- R6: A trial bit is kept when `cmp` of its channel is high in the trial cycle, and cleared otherwise. With an ideal comparator (input >= trial code), the result is the input truncated to N bits.
- R7: A result is stored left-aligned in 12 bits, with its low 12-N bits zero, in the slot named by the channel and input. `rd_data` shows slot `rd_slot` of channel `rd_ch` combinationally.
- R8: Slots outside a channel's mask keep their earlier contents during a scan.
- R9: `scan_done_irq` is a one-cycle pulse in the first cycle after the scan in which `busy` is low. A scan of S steps keeps `busy` high for S*(2+ext+N) cycles, where S is the larger mask population.
- R10: A trigger that arrives while a scan is busy is ignored. It neither lengthens the scan nor adds an interrupt.
- R11: After reset, `busy`, `sample_hold`, `scan_done_irq`, `mux_sel` and `dac_code` are zero, and every result slot reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_start | input | 1 | Software start strobe |
| hw_trig | input | 1 | Hardware trigger pulse |
| hw_trig_en | input | 1 | Enables the hardware trigger |
| res_sel | input | 2 | Resolution select, 6 + 2*value bits |
| sample_ext | input | 4 | Extra sample clocks, captured at trigger |
| scan_mask | input | 16 | Enable mask, channel c in bits [8c+7:8c] |
| cmp | input | 2 | Comparator result per channel |
| mux_sel | output | 6 | Input selector per channel, 3 bits each |
| dac_code | output | 24 | Trial code per channel, 12 bits each |
| sample_hold | output | 1 | High during the common sample phase |
| busy | output | 1 | Scan in progress |
| scan_done_irq | output | 1 | One-cycle scan-complete pulse |
| rd_ch | input | 1 | Channel of the result read |
| rd_slot | input | 3 | Input slot of the result read |
| rd_data | output | 12 | Selected result |

## Verification
Several internal faults show up at the ports within the step in which they occur. A wrong sample or bit counter changes the length of `sample_hold` or `busy`. A wrong scan pointer puts the wrong index on `mux_sel` on the first cycle of the affected step. Faults in the successive-approximation register or the result store corrupt data silently, and are seen only when the slots are read back after the interrupt. The bench therefore reads back every slot after every scan.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SAMPLE  = 2'd1,
        ST_CONVERT = 2'd2
    } scan_state_e;
endpackage

// File: rtl/scan_ptr.sv
module scan_ptr #(
    parameter int NMUX  = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic [NMUX-1:0]  mask,
    output logic [SEL_W-1:0] idx,
    output logic             active,
    output logic             more
);
    logic [NMUX-1:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pend_q <= '0;
        else if (load)    pend_q <= mask;
        else if (advance) pend_q <= pend_q & (pend_q - 1'b1);
    end

    always_comb begin
        idx = '0;
        for (int i = NMUX - 1; i >= 0; i--) begin
            if (pend_q[i]) idx = SEL_W'(i);
        end
    end

    assign active = |pend_q;
    assign more   = |(pend_q & (pend_q - 1'b1));

    // R3: each completed step retires exactly one enabled input
    p_ptr_retire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && active && !load) |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
    parameter int RES_W = 12,
    parameter int POS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             trial,
    input  logic [POS_W-1:0] pos,
    input  logic             cmp,
    output logic [RES_W-1:0] dac,
    output logic [RES_W-1:0] result
);
    logic [RES_W-1:0] sar_q;
    logic [RES_W-1:0] bit_w;
    logic [RES_W-1:0] low_mask;

    assign bit_w    = RES_W'(1) << pos;
    assign low_mask = (bit_w - 1'b1) | bit_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            sar_q <= '0;
        else if (clear)        sar_q <= '0;
        else if (trial && cmp) sar_q <= sar_q | bit_w;
    end

    assign dac    = trial ? (sar_q | bit_w) : sar_q;
    assign result = cmp ? (sar_q | bit_w) : sar_q;

    // R5: bits at and below the trial position are still undecided (zero)
    p_low_bits_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trial |-> ((sar_q & low_mask) == '0));
endmodule

// File: rtl/result_bank.sv
module result_bank #(
    parameter int NMUX  = 8,
    parameter int SEL_W = 3,
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] wr_slot,
    input  logic [RES_W-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_slot,
    output logic [RES_W-1:0] rd_data
);
    logic [RES_W-1:0] mem_q [NMUX];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NMUX; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[wr_slot] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_slot];

    // R7: a written result lands in its own slot
    p_slot_written_r7: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem_q[$past(wr_slot)] == $past(wr_data)));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int NMUX        = 8,
    parameter int RES_W       = 12,
    parameter int XTRA_W      = 4,
    parameter int BASE_SAMPLE = 2,
    localparam int SEL_W      = $clog2(NMUX),
    localparam int POS_W      = $clog2(RES_W),
    localparam int CH_W       = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CNT_W      = XTRA_W + 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sw_start,
    input  logic                   hw_trig,
    input  logic                   hw_trig_en,
    input  logic [1:0]             res_sel,
    input  logic [XTRA_W-1:0]      sample_ext,
    input  logic [NCH*NMUX-1:0]    scan_mask,
    input  logic [NCH-1:0]         cmp,
    output logic [NCH*SEL_W-1:0]   mux_sel,
    output logic [NCH*RES_W-1:0]   dac_code,
    output logic                   sample_hold,
    output logic                   busy,
    output logic                   scan_done_irq,
    input  logic [CH_W-1:0]        rd_ch,
    input  logic [SEL_W-1:0]       rd_slot,
    output logic [RES_W-1:0]       rd_data
);
    scan_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [POS_W-1:0]  pos_q;
    logic [POS_W-1:0]  lsb_q;
    logic [XTRA_W-1:0] ext_q;
    logic              irq_q;

    logic              start_req, any_mask, launch;
    logic              samp_last, bit_last, step_done, more_any;
    logic [NCH-1:0]    more_vec, active_vec;
    logic [RES_W-1:0]  bank_rd [NCH];

    assign start_req = sw_start | (hw_trig_en & hw_trig);
    assign any_mask  = |scan_mask;
    assign launch    = (state_q == ST_IDLE) && start_req && any_mask;
    assign samp_last = (cnt_q == CNT_W'(BASE_SAMPLE - 1) + CNT_W'(ext_q));
    assign bit_last  = (pos_q == lsb_q);
    assign step_done = (state_q == ST_CONVERT) && bit_last;
    assign more_any  = |more_vec;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (launch)    state_d = ST_SAMPLE;
            ST_SAMPLE:  if (samp_last) state_d = ST_CONVERT;
            ST_CONVERT: if (bit_last)  state_d = more_any ? ST_SAMPLE : ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pos_q <= '0;
            lsb_q <= '0;
            ext_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= step_done && !more_any;
            cnt_q <= (state_q == ST_SAMPLE) ? cnt_q + 1'b1 : '0;
            if (launch) begin
                ext_q <= sample_ext;
                lsb_q <= POS_W'({~res_sel, 1'b0});
            end
            if (state_q == ST_SAMPLE)       pos_q <= POS_W'(RES_W - 1);
            else if (state_q == ST_CONVERT) pos_q <= pos_q - 1'b1;
        end
    end

    always_comb begin
        busy          = (state_q != ST_IDLE);
        sample_hold   = (state_q == ST_SAMPLE);
        scan_done_irq = irq_q;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [SEL_W-1:0] idx;
        logic [RES_W-1:0] res;

        scan_ptr #(.NMUX(NMUX), .SEL_W(SEL_W)) u_ptr (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (launch),
            .advance (step_done),
            .mask    (scan_mask[c*NMUX +: NMUX]),
            .idx     (idx),
            .active  (active_vec[c]),
            .more    (more_vec[c])
        );

        sar_engine #(.RES_W(RES_W), .POS_W(POS_W)) u_sar (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (state_q == ST_SAMPLE),
            .trial  (state_q == ST_CONVERT),
            .pos    (pos_q),
            .cmp    (cmp[c]),
            .dac    (dac_code[c*RES_W +: RES_W]),
            .result (res)
        );

        result_bank #(.NMUX(NMUX), .SEL_W(SEL_W), .RES_W(RES_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (step_done && active_vec[c]),
            .wr_slot (idx),
            .wr_data (res),
            .rd_slot (rd_slot),
            .rd_data (bank_rd[c])
        );

        assign mux_sel[c*SEL_W +: SEL_W] = idx;
    end

    assign rd_data = bank_rd[rd_ch];

    // R1: an accepted software start makes the block busy next cycle
    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sw_start && any_mask) |=> busy);
    // R2: with nothing enabled an idle block stays idle
    p_empty_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !any_mask) |=> !busy);
    // R3: selector held while bits are resolved
    p_mux_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONVERT) |-> $stable(mux_sel));
    // R9: interrupt is a single pulse right after the scan
    p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done_irq |=> !scan_done_irq);
    p_irq_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done_irq |-> (!busy && $past(busy)));
endmodule

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_start = 1'b0, hw_trig = 1'b0, hw_trig_en = 1'b0;
    logic [1:0]  res_sel = 2'd3;
    logic [3:0]  sample_ext = 4'd0;
    logic [15:0] scan_mask = 16'h0;
    logic [1:0]  cmp;
    logic [5:0]  mux_sel;
    logic [23:0] dac_code;
    logic        sample_hold, busy, scan_done_irq;
    logic        rd_ch = 1'b0;
    logic [2:0]  rd_slot = 3'd0;
    logic [11:0] rd_data;

    logic [11:0] vin [2][8];
    logic [11:0] exp_res [2][8];
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    adc_scan_seq u_adc_scan_seq (
        .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .hw_trig(hw_trig),
        .hw_trig_en(hw_trig_en), .res_sel(res_sel), .sample_ext(sample_ext),
        .scan_mask(scan_mask), .cmp(cmp), .mux_sel(mux_sel), .dac_code(dac_code),
        .sample_hold(sample_hold), .busy(busy), .scan_done_irq(scan_done_irq),
        .rd_ch(rd_ch), .rd_slot(rd_slot), .rd_data(rd_data)
    );

    // behavioural comparators
    assign cmp[0] = vin[0][mux_sel[2:0]] >= dac_code[11:0];
    assign cmp[1] = vin[1][mux_sel[5:3]] >= dac_code[23:12];

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int popcnt(input logic [7:0] m);
        int n = 0;
        for (int i = 0; i < 8; i++) n += int'(m[i]);
        return n;
    endfunction

    function automatic int nth_set(input logic [7:0] m, input int k);
        int n = 0;
        for (int i = 0; i < 8; i++) begin
            if (m[i]) begin
                if (n == k) return i;
                n++;
            end
        end
        return -1;
    endfunction

    function automatic logic [11:0] trunc(input logic [11:0] v, input int r);
        int drop = 12 - (6 + 2 * r);
        return (v >> drop) << drop;
    endfunction

    task automatic check_slots(input string req);
        for (int c = 0; c < 2; c++) begin
            for (int s = 0; s < 8; s++) begin
                rd_ch = c[0];
                rd_slot = s[2:0];
                #1;
                chk(req, $sformatf("slot ch%0d in%0d", c, s), int'(rd_data), int'(exp_res[c][s]));
            end
        end
    endtask

    task automatic t_reset;
        chk("R11", "busy", int'(busy), 0);
        chk("R11", "irq", int'(scan_done_irq), 0);
        chk("R11", "sample_hold", int'(sample_hold), 0);
        chk("R11", "mux_sel", int'(mux_sel), 0);
        chk("R11", "dac_code", int'(dac_code), 0);
        check_slots("R11");
    endtask

    task automatic t_scan(input logic [7:0] ma, input logic [7:0] mb, input logic [1:0] r,
                          input logic [3:0] ext, input bit use_hw, input bit retrig);
        int steps, nb, busy_n, samp_n, irq_n, step;
        bit prev_samp;
        logic [7:0] m [2];
        m[0] = ma; m[1] = mb;
        steps = (popcnt(ma) > popcnt(mb)) ? popcnt(ma) : popcnt(mb);
        nb = 6 + 2 * int'(r);
        @(negedge clk);
        scan_mask = {mb, ma}; res_sel = r; sample_ext = ext;
        if (use_hw) begin hw_trig_en = 1'b1; hw_trig = 1'b1; end
        else sw_start = 1'b1;
        @(negedge clk);
        hw_trig = 1'b0; sw_start = 1'b0;
        chk("R1", "busy after trigger", int'(busy), 1);
        busy_n = 0; samp_n = 0; irq_n = 0; step = 0; prev_samp = 1'b0;
        for (int g = 0; g < 5000; g++) begin
            if (!busy) break;
            busy_n++;
            if (scan_done_irq) irq_n++;
            if (sample_hold) samp_n++;
            if (sample_hold && !prev_samp) begin
                for (int c = 0; c < 2; c++) begin
                    if (step < popcnt(m[c]))
                        chk("R3", $sformatf("mux ch%0d step%0d", c, step),
                            int'(mux_sel[c*3 +: 3]), nth_set(m[c], step));
                end
                step++;
            end
            if (prev_samp && !sample_hold) begin
                chk("R5", "first trial ch0", int'(dac_code[11:0]), 12'h800);
                chk("R5", "first trial ch1", int'(dac_code[23:12]), 12'h800);
            end
            prev_samp = sample_hold;
            sw_start = (retrig && busy_n == 3);
            hw_trig = (retrig && busy_n == 5);
            @(negedge clk);
        end
        sw_start = 1'b0; hw_trig = 1'b0;
        chk("R9", "busy cycles", busy_n, steps * (2 + int'(ext) + nb));
        chk("R4", "sample cycles", samp_n, steps * (2 + int'(ext)));
        chk("R3", "step count", step, steps);
        chk("R9", "irq during busy", irq_n, 0);
        chk("R9", "irq after scan", int'(scan_done_irq), 1);
        @(negedge clk);
        chk("R9", "irq one cycle", int'(scan_done_irq), 0);
        if (retrig) chk("R10", "no restart", int'(busy), 0);
        for (int c = 0; c < 2; c++)
            for (int s = 0; s < 8; s++)
                if (m[c][s]) exp_res[c][s] = trunc(vin[c][s], int'(r));
        check_slots("R6 R7 R8");
        hw_trig_en = 1'b0;
    endtask

    task automatic t_hw_disabled;
        @(negedge clk);
        scan_mask = 16'hFFFF; hw_trig_en = 1'b0; hw_trig = 1'b1;
        @(negedge clk);
        hw_trig = 1'b0;
        chk("R1", "hw trig disabled busy", int'(busy), 0);
        @(negedge clk);
        chk("R1", "hw trig disabled irq", int'(scan_done_irq), 0);
    endtask

    task automatic t_empty;
        @(negedge clk);
        scan_mask = 16'h0; sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        chk("R2", "empty mask busy", int'(busy), 0);
        @(negedge clk);
        chk("R2", "empty mask irq", int'(scan_done_irq), 0);
        check_slots("R2");
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog R9 actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 2; c++)
            for (int s = 0; s < 8; s++) begin
                vin[c][s] = 12'((c * 1234 + s * 517 + 300) % 4096);
                exp_res[c][s] = 12'h0;
            end
        vin[0][7] = 12'hFFF;
        vin[1][7] = 12'h000;
        vin[1][3] = 12'h7FF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hw_disabled();
        t_empty();
        t_scan(8'b1010_0101, 8'b0000_0110, 2'd3, 4'd0, 1'b0, 1'b0);
        t_scan(8'hFF, 8'h01, 2'd0, 4'd15, 1'b1, 1'b0);
        t_scan(8'h80, 8'h88, 2'd1, 4'd3, 1'b0, 1'b1);
        t_scan(8'h00, 8'h18, 2'd2, 4'd1, 1'b1, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule